// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block holds a single exclusive-access reservation for one processor context. A load-exclusive strobe records the granule address of its access and marks the reservation live. A later store-exclusive strobe is judged against that reservation. The block returns a registered pass or fail status together with a store-issue signal, so that a failing store never reaches memory.

Swap-type stores skip the judgement and always pass. To help spot livelock, the block counts back-to-back store-exclusive failures. It raises a one-cycle warning each time that count reaches a whole multiple of a fixed period, which is 100000 by default. The failure count saturates rather than wrapping. Snooping, arbitration between cores and the memory datapath are handled elsewhere.

Top module: `excl_monitor`

## Requirements
- R1: A load-exclusive stores its address with the low 4 bits ignored. A later non-swap store-exclusive to any byte of that same 16-byte granule passes.
- R2: A non-swap store-exclusive fails when its address, with the low 4 bits ignored, differs from the reserved granule in any bit.
- R3: A non-swap store-exclusive fails when no reservation is live.
- R4: A store-exclusive with the swap qualifier high always passes. It leaves the reservation and the failure count untouched.
- R5: A failing store-exclusive clears the reservation, so a following store to the reserved granule also fails.
- R6: A passing non-swap store-exclusive clears the reservation, so a second store to the same granule fails.
- R7: The response is available one cycle after the store strobe and lasts one cycle:
  - resp_valid_o is 1 for that cycle.
  - resp_pass_o is 1 for pass and 0 for fail.
  - store_issue_o is 1 only for a passing store.
- R8: livelock_warn_o pulses for exactly one cycle, alongside the response of the failure that brings the consecutive-failure count to a non-zero multiple of WARN_PERIOD.
- R9: A passing non-swap store-exclusive resets the consecutive-failure count to zero.
- R10: The failure count saturates at its maximum value. Once saturated, further failures raise no warning.
- R11: When load-exclusive and store-exclusive strobes arrive in the same cycle:
  - The store is judged against the reservation held before that cycle.
  - The reservation then holds the new load's granule.
- R12: Reset clears the reservation and the failure count, and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_excl_i | input | 1 | Load-exclusive strobe |
| st_excl_i | input | 1 | Store-exclusive strobe |
| st_swap_i | input | 1 | Marks the store as a swap that bypasses the check |
| addr_i | input | ADDR_W (32) | Physical address of the access |
| resp_valid_o | output | 1 | Store response valid, one cycle after the store strobe |
| resp_pass_o | output | 1 | Store status: 1 pass, 0 fail |
| store_issue_o | output | 1 | Store may be issued to memory |
| livelock_warn_o | output | 1 | One-cycle warning at every WARN_PERIOD consecutive failures |

## Verification
The hardest state to reach is the warning at the full default period, which needs 100000 consecutive failures. The bench holds the store strobe high with no live reservation for exactly that many cycles. It checks that the single pulse lines up with the last response.

Saturation and repeated warnings cannot be reached at the default width within the run budget. A second instance, with a 4-bit counter and a period of 5, receives the same stimulus. It shows warnings at 5, 10 and 15 failures, and silence after the counter saturates.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    // Result of judging one request cycle
    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,   // no store this cycle
        OUT_SWAP = 2'd1,   // swap store, passes without a check
        OUT_HIT  = 2'd2,   // checked store, reservation matched
        OUT_MISS = 2'd3    // checked store, rejected
    } st_outcome_e;

    // Strobes of one request cycle
    typedef struct packed {
        logic ld;
        logic st;
        logic swap;
    } excl_req_t;

    // Registered response bundle
    typedef struct packed {
        logic valid;
        logic pass;
        logic issue;
    } excl_resp_t;

    function automatic logic outcome_passes(st_outcome_e o);
        return (o == OUT_SWAP) || (o == OUT_HIT);
    endfunction

    function automatic logic outcome_checked(st_outcome_e o);
        return (o == OUT_HIT) || (o == OUT_MISS);
    endfunction

endpackage

// File: rtl/excl_resv_store.sv
module excl_resv_store #(
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              install_i,
    input  logic              drop_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              valid_o,
    output logic              tag_eq_o
);
    localparam int TAG_W = ADDR_W - GRAN_BITS;

    logic [TAG_W-1:0] tag_q;
    logic             valid_q;
    logic [TAG_W-1:0] req_tag;

    assign req_tag = addr_i[ADDR_W-1:GRAN_BITS];

    // A new load wins over the drop from a store judged in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (install_i) begin
            valid_q <= 1'b1;
            tag_q   <= req_tag;
        end else if (drop_i) begin
            valid_q <= 1'b0;
        end
    end

    assign valid_o  = valid_q;
    assign tag_eq_o = (tag_q == req_tag);
endmodule

// File: rtl/excl_judge.sv
module excl_judge
    import excl_mon_pkg::*;
(
    input  excl_req_t   req_i,
    input  logic        resv_valid_i,
    input  logic        tag_eq_i,
    output st_outcome_e outcome_o
);
    always_comb begin
        if (!req_i.st)
            outcome_o = OUT_IDLE;
        else if (req_i.swap)
            outcome_o = OUT_SWAP;
        else if (resv_valid_i && tag_eq_i)
            outcome_o = OUT_HIT;
        else
            outcome_o = OUT_MISS;
    end
endmodule

// File: rtl/excl_fail_tracker.sv
module excl_fail_tracker #(
    parameter int CNT_W       = 20,
    parameter int WARN_PERIOD = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_i,
    input  logic clear_i,
    output logic warn_o
);
    localparam int PHASE_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(WARN_PERIOD - 1);

    logic [CNT_W-1:0]   cnt_q;
    logic [PHASE_W-1:0] phase_q;
    logic               warn_q;
    logic               saturated;

    assign saturated = &cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q   <= '0;
            phase_q <= '0;
            warn_q  <= 1'b0;
        end else if (fail_i && !saturated) begin
            cnt_q <= cnt_q + 1'b1;
            if (phase_q == PHASE_LAST) begin
                phase_q <= '0;
                warn_q  <= 1'b1;
            end else begin
                phase_q <= phase_q + 1'b1;
                warn_q  <= 1'b0;
            end
        end else begin
            warn_q <= 1'b0;
        end
    end

    assign warn_o = warn_q;
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 4,
    parameter int CNT_W       = 20,
    parameter int WARN_PERIOD = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_excl_i,
    input  logic              st_excl_i,
    input  logic              st_swap_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              resp_valid_o,
    output logic              resp_pass_o,
    output logic              store_issue_o,
    output logic              livelock_warn_o
);
    excl_req_t   req;
    st_outcome_e outcome;
    logic        resv_valid;
    logic        tag_eq;
    excl_resp_t  resp_d, resp_q;

    assign req = '{ld: ld_excl_i, st: st_excl_i, swap: st_swap_i};

    excl_resv_store #(
        .ADDR_W   (ADDR_W),
        .GRAN_BITS(GRAN_BITS)
    ) u_resv (
        .clk      (clk),
        .rst      (rst),
        .install_i(req.ld),
        .drop_i   (outcome_checked(outcome)),
        .addr_i   (addr_i),
        .valid_o  (resv_valid),
        .tag_eq_o (tag_eq)
    );

    excl_judge u_judge (
        .req_i       (req),
        .resv_valid_i(resv_valid),
        .tag_eq_i    (tag_eq),
        .outcome_o   (outcome)
    );

    excl_fail_tracker #(
        .CNT_W      (CNT_W),
        .WARN_PERIOD(WARN_PERIOD)
    ) u_track (
        .clk    (clk),
        .rst    (rst),
        .fail_i (outcome == OUT_MISS),
        .clear_i(outcome == OUT_HIT),
        .warn_o (livelock_warn_o)
    );

    always_comb begin
        resp_d.valid = (outcome != OUT_IDLE);
        resp_d.pass  = outcome_passes(outcome);
        resp_d.issue = outcome_passes(outcome);
    end

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= resp_d;
    end

    assign resp_valid_o  = resp_q.valid;
    assign resp_pass_o   = resp_q.pass;
    assign store_issue_o = resp_q.issue;
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
    parameter int WARN_PERIOD = 100000
) (
    input logic clk,
    input logic rst,
    input logic ld_excl_i,
    input logic st_excl_i,
    input logic st_swap_i,
    input logic resv_valid,
    input logic resp_valid_o,
    input logic resp_pass_o,
    input logic store_issue_o,
    input logic livelock_warn_o
);
    // R7: a store strobe yields a response on the next cycle
    p_resp_after_strobe_r7: assert property (@(posedge clk) disable iff (rst)
        st_excl_i |=> resp_valid_o);

    // R7: no strobe, no response
    p_no_spurious_resp_r7: assert property (@(posedge clk) disable iff (rst)
        !st_excl_i |=> !resp_valid_o);

    // R7: a failed store is never issued
    p_fail_not_issued_r7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid_o && !resp_pass_o) |-> !store_issue_o);

    // R4: swap stores always pass
    p_swap_passes_r4: assert property (@(posedge clk) disable iff (rst)
        (st_excl_i && st_swap_i) |=> resp_pass_o);

    // R3: checked store with no live reservation fails
    p_noresv_fails_r3: assert property (@(posedge clk) disable iff (rst)
        (st_excl_i && !st_swap_i && !resv_valid) |=> !resp_pass_o);

    // R11: a load always leaves a live reservation
    p_load_installs_r11: assert property (@(posedge clk) disable iff (rst)
        ld_excl_i |=> resv_valid);

    // R8: warning only comes with a failure response
    p_warn_on_fail_r8: assert property (@(posedge clk) disable iff (rst)
        livelock_warn_o |-> (resp_valid_o && !resp_pass_o));

    generate
        if (WARN_PERIOD > 1) begin : g_single
            // R8: the warning is a single-cycle pulse
            p_warn_single_r8: assert property (@(posedge clk) disable iff (rst)
                livelock_warn_o |=> !livelock_warn_o);
        end
    endgenerate
endmodule

bind excl_monitor excl_monitor_chk #(
    .WARN_PERIOD(WARN_PERIOD)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ld_excl_i      (ld_excl_i),
    .st_excl_i      (st_excl_i),
    .st_swap_i      (st_swap_i),
    .resv_valid     (resv_valid),
    .resp_valid_o   (resp_valid_o),
    .resp_pass_o    (resp_pass_o),
    .store_issue_o  (store_issue_o),
    .livelock_warn_o(livelock_warn_o)
);

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        ld = 1'b0, st = 1'b0, sw = 1'b0;
    logic [31:0] addr = '0;
    logic        rv, rp, iss, warn;
    logic        rv_s, rp_s, iss_s, warn_s;
    int          errors = 0;
    int          checks = 0;

    always #4 clk = ~clk;  // 125 MHz

    excl_monitor dut (
        .clk(clk), .rst(rst), .ld_excl_i(ld), .st_excl_i(st), .st_swap_i(sw),
        .addr_i(addr), .resp_valid_o(rv), .resp_pass_o(rp),
        .store_issue_o(iss), .livelock_warn_o(warn));

    // Small instance: 4-bit counter (saturates at 15), warning every 5 failures
    excl_monitor #(.CNT_W(4), .WARN_PERIOD(5)) dut_sat (
        .clk(clk), .rst(rst), .ld_excl_i(ld), .st_excl_i(st), .st_swap_i(sw),
        .addr_i(addr), .resp_valid_o(rv_s), .resp_pass_o(rp_s),
        .store_issue_o(iss_s), .livelock_warn_o(warn_s));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ld = 0; st = 0; sw = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive one request cycle; on return the outputs show its response
    task automatic step(input logic l, input logic s, input logic w, input logic [31:0] a);
        @(negedge clk);
        ld = l; st = s; sw = w; addr = a;
        @(negedge clk);
        ld = 0; st = 0; sw = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R12 valid after reset", rv, 0);
        chk("R12 pass after reset", rp, 0);
        chk("R12 issue after reset", iss, 0);
        chk("R12 warn after reset", warn, 0);
        step(0, 1, 0, 32'h0000_1230);
        chk("R12 store after reset fails", rp, 0);
        chk("R3 store without reservation fails", {rv, rp, iss}, 3'b100);
    endtask

    task automatic t_granule();
        do_reset();
        step(1, 0, 0, 32'h0000_1230);
        step(0, 1, 0, 32'h0000_123C);
        chk("R1 same granule other byte passes", rp, 1);
        chk("R7 pass response", {rv, iss}, 2'b11);
        @(negedge clk);
        chk("R7 response lasts one cycle", rv, 0);
    endtask

    task automatic t_mismatch();
        do_reset();
        step(1, 0, 0, 32'h0000_1230);
        step(0, 1, 0, 32'h0000_1240);
        chk("R2 neighbour granule fails", {rv, rp, iss}, 3'b100);
        step(1, 0, 0, 32'h8000_1230);
        step(0, 1, 0, 32'h0000_1230);
        chk("R2 top bit differs fails", rp, 0);
    endtask

    task automatic t_swap();
        do_reset();
        step(0, 1, 1, 32'h0000_5000);
        chk("R4 swap passes with no reservation", {rv, rp, iss}, 3'b111);
        step(1, 0, 0, 32'h0000_6000);
        step(0, 1, 1, 32'h0000_7000);
        chk("R4 swap to other granule passes", rp, 1);
        step(0, 1, 0, 32'h0000_6008);
        chk("R4 reservation kept across swap", rp, 1);
    endtask

    task automatic t_fail_clears();
        do_reset();
        step(1, 0, 0, 32'h0000_A000);
        step(0, 1, 0, 32'h0000_B000);
        chk("R5 mismatched store fails", rp, 0);
        step(0, 1, 0, 32'h0000_A000);
        chk("R5 reservation dropped after fail", rp, 0);
    endtask

    task automatic t_pass_clears();
        do_reset();
        step(1, 0, 0, 32'h0000_C010);
        step(0, 1, 0, 32'h0000_C010);
        chk("R6 first store passes", rp, 1);
        step(0, 1, 0, 32'h0000_C010);
        chk("R6 second store fails", {rv, rp, iss}, 3'b100);
    endtask

    task automatic t_collide();
        do_reset();
        step(1, 0, 0, 32'h0000_1000);
        step(1, 1, 0, 32'h0000_1000);
        chk("R11 store judged on old reservation (hit)", rp, 1);
        step(0, 1, 0, 32'h0000_1000);
        chk("R11 new reservation installed", rp, 1);
        do_reset();
        step(1, 1, 0, 32'h0000_2000);
        chk("R11 store judged on old reservation (none)", rp, 0);
        step(0, 1, 0, 32'h0000_2000);
        chk("R11 load survives same-cycle failure", rp, 1);
    endtask

    task automatic t_warn_small();
        int hits = 0;
        do_reset();
        for (int i = 1; i <= 10; i++) begin
            step(0, 1, 0, 32'h0);
            if (warn_s !== ((i % 5) == 0)) hits++;
        end
        chk("R8 warn at 5 and 10 failures only", hits, 0);
    endtask

    task automatic t_counter_clear();
        int bad = 0;
        do_reset();
        for (int i = 0; i < 3; i++) step(0, 1, 0, 32'h0);
        step(1, 0, 0, 32'h0000_0100);
        step(0, 1, 0, 32'h0000_0100);
        chk("R9 clearing store passes", rp_s, 1);
        for (int i = 1; i <= 5; i++) begin
            step(0, 1, 0, 32'h0);
            if (warn_s !== (i == 5)) bad++;
        end
        chk("R9 count restarts after pass", bad, 0);
    endtask

    task automatic t_saturate();
        int bad = 0;
        do_reset();
        for (int i = 1; i <= 25; i++) begin
            step(0, 1, 0, 32'h0);
            if (warn_s !== (i == 5 || i == 10 || i == 15)) bad++;
        end
        chk("R10 no warning once saturated", bad, 0);
    endtask

    task automatic t_long();
        int bad = 0;
        int pulses = 0;
        do_reset();
        @(negedge clk);
        st = 1; sw = 0; addr = 32'h0000_4440;
        for (int i = 1; i <= 100000; i++) begin
            @(negedge clk);
            if (i == 100000) st = 0;
            if (warn) pulses++;
            if (warn !== (i == 100000)) bad++;
        end
        chk("R8 warn only at 100000th failure", bad, 0);
        chk("R8 exactly one pulse", pulses, 1);
        @(negedge clk);
        chk("R8 pulse lasts one cycle", warn, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_granule();
        t_mismatch();
        t_swap();
        t_fail_clears();
        t_pass_clears();
        t_collide();
        t_warn_small();
        t_counter_clear();
        t_saturate();
        t_long();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule